// File: doc/BRIEF.md
# Single-Channel Conversion Read Sequencer

This block drives one complete read of a single conversion channel from one device on a daisy-chained battery-monitor link. A request names the target device, the channel and an averaging code. The block then hands three register writes to an external frame builder, which adds the CRC and serialises each write as a 32-bit SPI word (mode 1, at most 700 kHz). These writes point the target's readback register at the channel, silence readback on every part, and then re-enable readback on the target with a conversion started by chip select.

Once the writes are done, the block waits for the conversion to finish. The wait is measured in ticks of a 1 µs strobe and depends on the acquisition-time setting, the averaging code and the number of devices in the chain. After the wait it asks the SPI word engine to clock in one 32-bit frame while sending a fixed filler word. The returned frame is checked against the request, and the block reports a 12-bit result together with a status code.

Top module: `conv_read_seq`

## Requirements
- R1: After reset, busy, done, wr_valid and rd_req are low, and status and result are zero.
- R2: A request with req_valid high while busy is low is accepted, and busy is high from the following cycle. A req_valid pulse while busy is high starts nothing and does not alter the transaction in flight.
- R3: The first write goes to the requested device, register 0x1C, with wr_all low. Its value carries the channel in bits 5:2 and zeros in bits 7:6 and 1:0.
- R4: The second write goes to device 0, register 0x0D, with wr_all high. Its value holds 00 in bits 7:6 (convert all inputs), 11 in bits 5:4 (no readback), 0 in bit 3, the averaging code in bits 2:1 and 0 in bit 0.
- R5: The third write goes to the requested device, register 0x0D, with wr_all low. Its value holds 00 in bits 7:6, 00 in bits 5:4 (readback all), 1 in bit 3 (start on chip select), the averaging code in bits 2:1 and 0 in bit 0.
- R6: Exactly three writes are issued, one at a time and in the order R3, R4, R5. Each write holds wr_valid and all its fields stable until wr_ready is seen, and wr_valid and rd_req are never high together.
- R7: After the third write is accepted, rd_req rises after exactly ceil((T + 5000)/1000) us_tick pulses, where T = (tacq + 720)·12·2^avg − tacq + 250·tail ns. tacq is 470, 1030, 1510 or 1945 ns for acquisition codes 0 to 3, and tail is the number of devices after the first. The acquisition code and tail are taken at request time.
- R8: rd_req stays high until rd_done, and rd_tx carries 0xF800030A while rd_req is high.
- R9: The received frame is read as follows: device address in bits 31:27, channel in bits 26:23, data in bits 22:11. If the CRC is good and both addresses match the request, status is 00 (ok) and result is the data field.
- R10: If rd_crc_ok is low, status is 01 (CRC error) and result is 0. This outcome takes priority over any address mismatch.
- R11: If the CRC is good but the device or channel address differs from the request, status is 10 (address error) and result is 0.
- R12: done is a single-cycle pulse issued with busy low, in the cycle after rd_done. status and result keep their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_acq | input | 2 | Acquisition-time code, sampled at request |
| cfg_tail | input | TAIL_W | Number of devices after the first, sampled at request |
| req_valid | input | 1 | Request strobe |
| req_dev | input | 5 | Target device address |
| req_chan | input | 4 | Target channel address |
| req_avg | input | 2 | Averaging code (1, 2, 4, 8 samples) |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| wr_valid | output | 1 | Write request to frame builder |
| wr_ready | input | 1 | Frame builder has taken the write |
| wr_dev | output | 5 | Write device address |
| wr_reg | output | 6 | Write register address |
| wr_val | output | 8 | Write register value |
| wr_all | output | 1 | Write addresses all parts |
| rd_req | output | 1 | Request to clock in one result word |
| rd_tx | output | 32 | Filler word sent during the result read |
| rd_done | input | 1 | Result word received |
| rd_rx | input | 32 | Received result word |
| rd_crc_ok | input | 1 | CRC verdict on rd_rx from the codec |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| status | output | 2 | 00 ok, 01 CRC error, 10 address error |
| result | output | 12 | Conversion data, zero on error |

## Verification
The main read is run with six requests that cover all four averaging codes, all four acquisition codes, and tail counts of 0 and 7. Because each combination gives a different tick count, a mistake in the tacq table, in the averaging shift or in the chain term shows up as a wrong wait. The same six requests also return frames with a good match, a bad CRC that also carries a wrong device address (checking the priority between the two errors), a device-only mismatch and a channel-only mismatch. Running these frames shows whether each address field is compared separately and whether the result is cleared on error. The bench holds wr_ready low on alternate cycles, so writes must stay stable under backpressure. A request issued in mid-transaction is used to test that busy requests are ignored.

// File: rtl/conv_read_seq_pkg.sv
package conv_read_seq_pkg;

    localparam int DEV_W   = 5;
    localparam int CHAN_W  = 4;
    localparam int DATA_W  = 12;
    localparam int REG_W   = 6;
    localparam int VAL_W   = 8;
    localparam int WORD_W  = 32;

    // positions inside a received conversion frame
    localparam int RX_DEV_LSB  = 27;
    localparam int RX_CHAN_LSB = 23;
    localparam int RX_DATA_LSB = 11;

    localparam logic [REG_W-1:0]  REG_READ_SEL = 6'h1C;
    localparam logic [REG_W-1:0]  REG_CTRL_HI  = 6'h0D;
    localparam logic [DEV_W-1:0]  DEV_MASTER   = '0;
    localparam logic [WORD_W-1:0] FILLER_WORD  = 32'hF800_030A;

    localparam logic [1:0] INPUT_ALL  = 2'b00;
    localparam logic [1:0] READBK_ALL = 2'b00;
    localparam logic [1:0] READBK_OFF = 2'b11;

    localparam int CONV_NS       = 720;
    localparam int CONV_PER_PART = 12;
    localparam int CHAIN_STEP_NS = 250;
    localparam int SETTLE_NS     = 5000;
    localparam int TICK_NS       = 1000;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SEL,
        SQ_OFF,
        SQ_ON,
        SQ_WAIT,
        SQ_READ
    } seq_state_e;

    typedef enum logic [1:0] {
        RS_OK       = 2'b00,
        RS_CRC_ERR  = 2'b01,
        RS_ADDR_ERR = 2'b10
    } rd_status_e;

    function automatic logic [11:0] acq_time_ns(input logic [1:0] code);
        case (code)
            2'd0:    acq_time_ns = 12'd470;
            2'd1:    acq_time_ns = 12'd1030;
            2'd2:    acq_time_ns = 12'd1510;
            default: acq_time_ns = 12'd1945;
        endcase
    endfunction

endpackage

// File: rtl/seq_conv_delay.sv
module seq_conv_delay
    import conv_read_seq_pkg::*;
#(
    parameter int TAIL_W = 3,
    parameter int NS_W   = 20
) (
    input  logic [1:0]        acq,
    input  logic [1:0]        avg,
    input  logic [TAIL_W-1:0] tail,
    output logic [NS_W-1:0]   wait_ns
);
    logic [NS_W-1:0] tacq;
    logic [NS_W-1:0] per_sample;
    logic [NS_W-1:0] chain_ns;

    always_comb begin
        tacq       = NS_W'(acq_time_ns(acq));
        per_sample = (tacq + NS_W'(CONV_NS)) * NS_W'(CONV_PER_PART);
        chain_ns   = NS_W'(tail) * NS_W'(CHAIN_STEP_NS);
        wait_ns    = (per_sample << avg) - tacq + chain_ns;
    end
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer
    import conv_read_seq_pkg::*;
#(
    parameter int NS_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [NS_W-1:0] load_ns,
    input  logic            tick,
    output logic            fire
);
    typedef struct packed {
        logic [NS_W-1:0] rem;
        logic            run;
    } tmr_t;

    tmr_t t_d, t_q;

    assign fire = t_q.run && tick && (t_q.rem <= NS_W'(TICK_NS));

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.rem = load_ns + NS_W'(SETTLE_NS);
            t_d.run = 1'b1;
        end else if (t_q.run && tick) begin
            if (fire) begin
                t_d.run = 1'b0;
                t_d.rem = '0;
            end else begin
                t_d.rem = t_q.rem - NS_W'(TICK_NS);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/seq_result_check.sv
module seq_result_check
    import conv_read_seq_pkg::*;
(
    input  logic [WORD_W-1:0] rx,
    input  logic              crc_ok,
    input  logic [DEV_W-1:0]  exp_dev,
    input  logic [CHAN_W-1:0] exp_chan,
    output rd_status_e        verdict,
    output logic [DATA_W-1:0] data
);
    logic [DEV_W-1:0]  got_dev;
    logic [CHAN_W-1:0] got_chan;
    logic [DATA_W-1:0] got_data;
    logic              unused_rx_tail;

    assign got_dev        = rx[RX_DEV_LSB  +: DEV_W];
    assign got_chan       = rx[RX_CHAN_LSB +: CHAN_W];
    assign got_data       = rx[RX_DATA_LSB +: DATA_W];
    assign unused_rx_tail = ^rx[RX_DATA_LSB-1:0];

    always_comb begin
        verdict = RS_OK;
        data    = got_data;
        if (!crc_ok) begin
            verdict = RS_CRC_ERR;
            data    = '0;
        end else if ((got_dev != exp_dev) || (got_chan != exp_chan)) begin
            verdict = RS_ADDR_ERR;
            data    = '0;
        end
    end
endmodule

// File: rtl/conv_read_seq.sv
module conv_read_seq
    import conv_read_seq_pkg::*;
#(
    parameter int TAIL_W = 3,
    parameter int NS_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_acq,
    input  logic [TAIL_W-1:0] cfg_tail,
    input  logic              req_valid,
    input  logic [4:0]        req_dev,
    input  logic [3:0]        req_chan,
    input  logic [1:0]        req_avg,
    input  logic              us_tick,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [4:0]        wr_dev,
    output logic [5:0]        wr_reg,
    output logic [7:0]        wr_val,
    output logic              wr_all,
    output logic              rd_req,
    output logic [31:0]       rd_tx,
    input  logic              rd_done,
    input  logic [31:0]       rd_rx,
    input  logic              rd_crc_ok,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [11:0]       result
);
    localparam int PAD_W = VAL_W - CHAN_W - 2;

    typedef struct packed {
        seq_state_e        state;
        logic [DEV_W-1:0]  dev;
        logic [CHAN_W-1:0] chan;
        logic [1:0]        avg;
        logic [1:0]        acq;
        logic [TAIL_W-1:0] tail;
        logic              done;
        rd_status_e        status;
        logic [DATA_W-1:0] result;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [NS_W-1:0]   wait_ns;
    logic              tmr_load;
    logic              tmr_fire;
    rd_status_e        chk_verdict;
    logic [DATA_W-1:0] chk_data;

    seq_conv_delay #(.TAIL_W(TAIL_W), .NS_W(NS_W)) u_delay (
        .acq     (r_q.acq),
        .avg     (r_q.avg),
        .tail    (r_q.tail),
        .wait_ns (wait_ns)
    );

    seq_wait_timer #(.NS_W(NS_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_ns (wait_ns),
        .tick    (us_tick),
        .fire    (tmr_fire)
    );

    seq_result_check u_check (
        .rx       (rd_rx),
        .crc_ok   (rd_crc_ok),
        .exp_dev  (r_q.dev),
        .exp_chan (r_q.chan),
        .verdict  (chk_verdict),
        .data     (chk_data)
    );

    assign tmr_load = (r_q.state == SQ_ON) && wr_ready;

    // write fields per preamble step
    always_comb begin
        wr_valid = 1'b0;
        wr_dev   = r_q.dev;
        wr_reg   = REG_CTRL_HI;
        wr_val   = '0;
        wr_all   = 1'b0;
        case (r_q.state)
            SQ_SEL: begin
                wr_valid = 1'b1;
                wr_reg   = REG_READ_SEL;
                wr_val   = {{PAD_W{1'b0}}, r_q.chan, 2'b00};
            end
            SQ_OFF: begin
                wr_valid = 1'b1;
                wr_dev   = DEV_MASTER;
                wr_all   = 1'b1;
                wr_val   = {INPUT_ALL, READBK_OFF, 1'b0, r_q.avg, 1'b0};
            end
            SQ_ON: begin
                wr_valid = 1'b1;
                wr_val   = {INPUT_ALL, READBK_ALL, 1'b1, r_q.avg, 1'b0};
            end
            default: ;
        endcase
    end

    assign rd_req = (r_q.state == SQ_READ);
    assign rd_tx  = rd_req ? FILLER_WORD : '0;
    assign busy   = (r_q.state != SQ_IDLE);
    assign done   = r_q.done;
    assign status = r_q.status;
    assign result = r_q.result;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            SQ_IDLE: begin
                if (req_valid) begin
                    r_d.state = SQ_SEL;
                    r_d.dev   = req_dev;
                    r_d.chan  = req_chan;
                    r_d.avg   = req_avg;
                    r_d.acq   = cfg_acq;
                    r_d.tail  = cfg_tail;
                end
            end
            SQ_SEL:  if (wr_ready) r_d.state = SQ_OFF;
            SQ_OFF:  if (wr_ready) r_d.state = SQ_ON;
            SQ_ON:   if (wr_ready) r_d.state = SQ_WAIT;
            SQ_WAIT: if (tmr_fire) r_d.state = SQ_READ;
            SQ_READ: begin
                if (rd_done) begin
                    r_d.state  = SQ_IDLE;
                    r_d.done   = 1'b1;
                    r_d.status = chk_verdict;
                    r_d.result = chk_data;
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/conv_read_seq_checker.sv
module conv_read_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [4:0]  wr_dev,
    input logic [5:0]  wr_reg,
    input logic [7:0]  wr_val,
    input logic        wr_all,
    input logic        rd_req,
    input logic        rd_done,
    input logic        done,
    input logic [1:0]  status,
    input logic [11:0] result
);
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable({wr_dev, wr_reg, wr_val, wr_all})));

    p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !rd_req);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done) |=> rd_req);

    p_status_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'b11));

    p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status != 2'b00)) |-> (result == 12'd0));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({status, result}) |-> done);
endmodule

bind conv_read_seq conv_read_seq_checker u_conv_read_seq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_dev    (wr_dev),
    .wr_reg    (wr_reg),
    .wr_val    (wr_val),
    .wr_all    (wr_all),
    .rd_req    (rd_req),
    .rd_done   (rd_done),
    .done      (done),
    .status    (status),
    .result    (result)
);

// File: tb/conv_read_seq_bench.sv
module conv_read_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {dev, chan, avg, acq, tail, data, kind}; kind 0 ok, 1 bad crc + wrong dev, 2 wrong dev, 3 wrong chan
    localparam logic [29:0] VEC [NVEC] = '{
        {5'h03, 4'h2, 2'd0, 2'd0, 3'd0, 12'hABC, 2'd0},
        {5'h1E, 4'hB, 2'd3, 2'd3, 3'd7, 12'hFFF, 2'd0},
        {5'h10, 4'h0, 2'd1, 2'd2, 3'd3, 12'h000, 2'd0},
        {5'h07, 4'h5, 2'd2, 2'd1, 3'd1, 12'h123, 2'd1},
        {5'h00, 4'h9, 2'd0, 2'd1, 3'd2, 12'h456, 2'd2},
        {5'h15, 4'h3, 2'd2, 2'd0, 3'd5, 12'h789, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_acq = '0;
    logic [2:0]  cfg_tail = '0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [3:0]  req_chan = '0;
    logic [1:0]  req_avg = '0;
    logic        us_tick = 1'b0;
    logic        wr_ready = 1'b0;
    logic        rd_done = 1'b0;
    logic [31:0] rd_rx = '0;
    logic        rd_crc_ok = 1'b0;
    logic        wr_valid, wr_all, rd_req, busy, done;
    logic [4:0]  wr_dev;
    logic [5:0]  wr_reg;
    logic [7:0]  wr_val;
    logic [31:0] rd_tx;
    logic [1:0]  status;
    logic [11:0] result;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tick_div = 0;
    int rsp_wait = 0;
    logic [31:0] rsp_word = '0;
    logic        rsp_crc = 1'b1;
    int wcnt = 0;
    logic [4:0] w_dev [3];
    logic [5:0] w_reg [3];
    logic [7:0] w_val [3];
    logic       w_all [3];
    logic in_wait = 1'b0;
    int tick_cnt = 0;
    int got_ticks = -1;
    logic [31:0] seen_tx = '0;

    conv_read_seq u_conv_read_seq (
        .clk(clk), .rst_n(rst_n), .cfg_acq(cfg_acq), .cfg_tail(cfg_tail),
        .req_valid(req_valid), .req_dev(req_dev), .req_chan(req_chan), .req_avg(req_avg),
        .us_tick(us_tick), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dev(wr_dev),
        .wr_reg(wr_reg), .wr_val(wr_val), .wr_all(wr_all), .rd_req(rd_req), .rd_tx(rd_tx),
        .rd_done(rd_done), .rd_rx(rd_rx), .rd_crc_ok(rd_crc_ok), .busy(busy), .done(done),
        .status(status), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // bus models and monitor, one process on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        wr_ready = ~wr_ready;
        tick_div = (tick_div + 1) % 4;
        us_tick  = (tick_div == 0);
        if (rd_done) begin
            rd_done = 1'b0;
        end else if (rd_req) begin
            if (rsp_wait == 2) begin
                rd_done = 1'b1; rd_rx = rsp_word; rd_crc_ok = rsp_crc; rsp_wait = 0;
            end else rsp_wait++;
        end else rsp_wait = 0;
        if (rd_req) seen_tx = rd_tx;
        if (in_wait && rd_req) begin
            in_wait = 1'b0; got_ticks = tick_cnt;
        end else if (in_wait && us_tick) tick_cnt++;
        if (rst_n && wr_valid && wr_ready) begin
            if (wcnt < 3) begin
                w_dev[wcnt] = wr_dev; w_reg[wcnt] = wr_reg;
                w_val[wcnt] = wr_val; w_all[wcnt] = wr_all;
            end
            wcnt++;
            if (wcnt == 3) begin in_wait = 1'b1; tick_cnt = 0; end
        end
    end

    function automatic int exp_ticks(input int acq, input int avg, input int tail);
        int t, ns;
        case (acq) 0: t = 470; 1: t = 1030; 2: t = 1510; default: t = 1945; endcase
        ns = (t + 720) * 12 * (1 << avg) - t + 250 * tail;
        return (ns + 5000 + 999) / 1000;
    endfunction

    task automatic issue(input logic [4:0] d, input logic [3:0] c, input logic [1:0] a,
                         input logic [1:0] q, input logic [2:0] tl);
        wcnt = 0; got_ticks = -1; seen_tx = '0;
        @(negedge clk);
        req_dev = d; req_chan = c; req_avg = a; cfg_acq = q; cfg_tail = tl;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    initial begin
        logic seen;
        logic [29:0] v;
        logic [4:0] d; logic [3:0] c; logic [1:0] a, q, kind; logic [2:0] tl; logic [11:0] dat;
        logic [4:0] rd_dev; logic [3:0] rd_ch;
        int exp_st; int exp_res;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !wr_valid && !rd_req, "R1 idle outputs", {busy, done, wr_valid, rd_req}, 0);
        check(status == 0 && result == 0, "R1 status/result", {status, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            {d, c, a, q, tl, dat, kind} = v;
            rd_dev = (kind == 1 || kind == 2) ? (d ^ 5'h01) : d;
            rd_ch  = (kind == 3) ? (c ^ 4'h1) : c;
            rsp_word = {rd_dev, rd_ch, dat, 1'b0, 8'h5A, 2'b00};
            rsp_crc  = (kind != 1);
            exp_st   = (kind == 0) ? 0 : (kind == 1) ? 1 : 2;
            exp_res  = (kind == 0) ? int'(dat) : 0;
            issue(d, c, a, q, tl);
            // R2: busy one cycle after acceptance
            check(busy, "R2 busy after request", busy, 1);
            wait_done(seen);
            check(seen, "R12 done seen", seen, 1);
            check(!busy, "R12 busy low with done", busy, 0);
            check(wcnt == 3, "R6 write count", wcnt, 3);
            check(w_dev[0] == d && w_reg[0] == 6'h1C && w_val[0] == {2'b00, c, 2'b00} && !w_all[0],
                  "R3 first write", {w_dev[0], w_reg[0], w_val[0], w_all[0]}, {d, 6'h1C, 2'b00, c, 2'b00, 1'b0});
            check(w_dev[1] == 0 && w_reg[1] == 6'h0D && w_val[1] == {5'b00110, a, 1'b0} && w_all[1],
                  "R4 second write", {w_dev[1], w_reg[1], w_val[1], w_all[1]}, {5'd0, 6'h0D, 5'b00110, a, 1'b0, 1'b1});
            check(w_dev[2] == d && w_reg[2] == 6'h0D && w_val[2] == {5'b00001, a, 1'b0} && !w_all[2],
                  "R5 third write", {w_dev[2], w_reg[2], w_val[2], w_all[2]}, {d, 6'h0D, 5'b00001, a, 1'b0, 1'b0});
            check(got_ticks == exp_ticks(int'(q), int'(a), int'(tl)), "R7 wait ticks",
                  got_ticks, exp_ticks(int'(q), int'(a), int'(tl)));
            check(seen_tx == 32'hF800030A, "R8 filler word", seen_tx, 32'hF800030A);
            check(int'(status) == exp_st, (kind == 0) ? "R9 status ok" : (kind == 1) ? "R10 crc status" : "R11 addr status",
                  status, exp_st);
            check(int'(result) == exp_res, (kind == 0) ? "R9 result data" : "R11 result cleared", result, exp_res);
            @(negedge clk);
            check(!done, "R12 done single cycle", done, 0);
            check(int'(status) == exp_st && int'(result) == exp_res, "R12 held after done", {status, result}, {exp_st[1:0], exp_res[11:0]});
        end

        // R2: request during busy is ignored
        rsp_word = {5'h03, 4'h2, 12'h5A5, 1'b0, 8'h00, 2'b00};
        rsp_crc  = 1'b1;
        issue(5'h03, 4'h2, 2'd0, 2'd0, 3'd0);
        repeat (20) @(negedge clk);
        req_dev = 5'h1F; req_chan = 4'hF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(seen);
        check(seen && status == 0 && result == 12'h5A5, "R2 busy request ignored result", {status, result}, 12'h5A5);
        check(wcnt == 3 && w_dev[2] == 5'h03, "R2 busy request no extra writes", wcnt, 3);
        repeat (10) @(negedge clk);
        check(!busy && wcnt == 3, "R2 no second transaction", {busy, wcnt[7:0]}, 3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule